// File: doc/BRIEF.md
# DDR3 Mode Register Programming Sequencer

This block sits on the controller side of a DDR3 interface and writes the device's four mode registers. Each write is a Mode Register Set (MRS) command. After reset, the system asserts `init_req` once and the block writes all four registers. During normal operation, `upd_req` together with a register mask rewrites any subset of them. Mode register contents are undefined after power-up and must be rewritten, so the block always sends a full register image and never a partial field. It takes a snapshot of the four images when each sequence starts.

While a sequence runs, the block owns the command bus. It drives MRS commands with NOP cycles between them. It keeps MRS commands apart by the run-time gap `t_mrd`. It holds `busy` high until `t_mod` cycles have passed after the last MRS, and the scheduler must not issue any other command during that time. The block also forces the outgoing ODT signal low for the whole sequence. When nominal termination is enabled, it adds a lead-in so that ODT is low for `t_odtloff`+1 cycles before the first MRS.

A request that arrives while a sequence is running is queued. It is serviced when the running settle time ends.

Top module: `mrs_sequencer`

## Requirements
- R1: After reset the command outputs show deselect ({cs_n,ras_n,cas_n,we_n} = 4'b1111), `busy` and `done` are low, and `odt` follows `odt_req`.
- R2: An MRS is driven as cs_n=ras_n=cas_n=we_n=0 for exactly one cycle. `ba` carries the register number (0..3) zero-extended, and `addr` carries that register's full image.
- R3: Within a sequence, selected registers are written in the order 2, 3, 1, 0. `init_req` selects all four. `upd_mask` bit i selects register i.
- R4: ODT is forced low from the first cycle after a request is accepted. The first MRS follows after exactly `t_odtloff`+1 ODT-low cycles when `rtt_nom_on` is high, and after 1 such cycle otherwise.
- R5: Consecutive MRS commands in a sequence are exactly max(`t_mrd`,1) cycles apart.
- R6: `busy` is high from the cycle after acceptance until max(`t_mod`,1) cycles after the last MRS. Non-MRS cycles during `busy` carry NOP (4'b0111), and idle cycles carry deselect.
- R7: `done` is high for exactly one cycle: the cycle in which the settle time of a sequence has ended.
- R8: `odt` is low whenever `busy` is high, and equals `odt_req` otherwise.
- R9: A request accepted while `busy` is high is queued. Its sequence starts when the running settle time ends, with `busy` staying high, and it uses the images present at that moment.
- R10: A request whose register mask is zero is ignored: no command, no `busy`, no `done`.
- R11: Image inputs that change after a sequence has started do not alter the addresses that sequence sends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_req | input | 1 | Request writing of all four registers |
| upd_req | input | 1 | Request writing of the registers in `upd_mask` |
| upd_mask | input | 4 | Register select for `upd_req`, bit i = register i |
| mr0_img | input | ADDR_W | Full image for register 0 |
| mr1_img | input | ADDR_W | Full image for register 1 |
| mr2_img | input | ADDR_W | Full image for register 2 |
| mr3_img | input | ADDR_W | Full image for register 3 |
| rtt_nom_on | input | 1 | Nominal termination enabled, adds ODT lead-in |
| t_mrd | input | CNT_W | MRS-to-MRS gap in cycles |
| t_mod | input | CNT_W | MRS-to-other-command settle time in cycles |
| t_odtloff | input | CNT_W | ODT turn-off latency in cycles |
| odt_req | input | 1 | ODT wanted by the scheduler |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address, register number during MRS |
| addr | output | ADDR_W | Address bus, register image during MRS |
| odt | output | 1 | Gated on-die termination control |
| busy | output | 1 | Sequence in progress, other commands forbidden |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench aims at timing edges:
- a zero `t_mrd`, which a design without clamping would turn into back-to-back MRS commands;
- the ODT lead-in with termination on and off, where an off-by-one would issue the MRS while ODT was still high;
- the exact cycle in which `busy` falls, where a short settle count would let the scheduler issue a command too early.

It changes the images right after a sequence starts, which a design without a snapshot would leak into the later MRS addresses. It queues a second request mid-sequence, which a design without a queue would drop or start before the settle time ends. A zero-mask request checks that no empty sequence produces a stray `busy` or `done`.

// File: rtl/mrs_pkg.sv
`timescale 1ns/1ps
package mrs_pkg;
   localparam int NUM_MR = 4;
   localparam int SEL_W  = 2;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_GUARD  = 2'd1,
      ST_GAP    = 2'd2,
      ST_SETTLE = 2'd3
   } seq_state_t;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } ddr_cmd_t;

   localparam ddr_cmd_t CMD_MRS = 4'b0000;
   localparam ddr_cmd_t CMD_NOP = 4'b0111;
   localparam ddr_cmd_t CMD_DES = 4'b1111;

   // write order: slot 0 first
   function automatic int slot_reg(input int slot);
      case (slot)
         0:       return 2;
         1:       return 3;
         2:       return 1;
         default: return 0;
      endcase
   endfunction
endpackage

// File: rtl/mrs_timer.sv
`timescale 1ns/1ps
module mrs_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5
endmodule

// File: rtl/mrs_picker.sv
`timescale 1ns/1ps
module mrs_picker
   import mrs_pkg::*;
#(
   parameter int NUM = NUM_MR,
   localparam int SW = $clog2(NUM)
) (
   input  logic [NUM-1:0] mask,
   output logic           any,
   output logic [SW-1:0]  sel,
   output logic [NUM-1:0] rest
);
   always_comb begin
      sel = '0;
      any = 1'b0;
      for (int s = NUM - 1; s >= 0; s--) begin
         if (mask[slot_reg(s)]) begin
            sel = SW'(slot_reg(s));
            any = 1'b1;
         end
      end
      rest = mask & ~(NUM'(1) << sel);
   end
endmodule

// File: rtl/mrs_shadow.sv
`timescale 1ns/1ps
module mrs_shadow #(
   parameter int ADDR_W = 16,
   parameter int NUM    = 4,
   localparam int SW    = $clog2(NUM)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cap,
   input  logic [NUM*ADDR_W-1:0] img_flat,
   input  logic [SW-1:0]         rd_sel,
   output logic [ADDR_W-1:0]     rd_data
);
   logic [ADDR_W-1:0] bank [NUM];

   for (genvar g = 0; g < NUM; g++) begin : g_reg
      logic [ADDR_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)   q <= '0;
         else if (cap) q <= img_flat[g*ADDR_W +: ADDR_W];
      end
      assign bank[g] = q;
   end

   assign rd_data = bank[rd_sel];
endmodule

// File: rtl/mrs_sequencer.sv
`timescale 1ns/1ps
module mrs_sequencer
   import mrs_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int BA_W     = 3,
   parameter int CNT_W    = 8,
   parameter bit IDLE_NOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_req,
   input  logic              upd_req,
   input  logic [3:0]        upd_mask,
   input  logic [ADDR_W-1:0] mr0_img,
   input  logic [ADDR_W-1:0] mr1_img,
   input  logic [ADDR_W-1:0] mr2_img,
   input  logic [ADDR_W-1:0] mr3_img,
   input  logic              rtt_nom_on,
   input  logic [CNT_W-1:0]  t_mrd,
   input  logic [CNT_W-1:0]  t_mod,
   input  logic [CNT_W-1:0]  t_odtloff,
   input  logic              odt_req,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr,
   output logic              odt,
   output logic              busy,
   output logic              done
);
   localparam int GAP_W = CNT_W + 1;

   if (ADDR_W < 14) begin : g_bad_addr
      $error("ADDR_W must hold a full mode register image");
   end
   if (BA_W < SEL_W) begin : g_bad_ba
      $error("BA_W too narrow for register select");
   end
   if (CNT_W < 4) begin : g_bad_cnt
      $error("CNT_W too narrow for timing values");
   end

   ddr_cmd_t idle_cmd;
   if (IDLE_NOP) begin : g_idle_nop
      assign idle_cmd = CMD_NOP;
   end else begin : g_idle_des
      assign idle_cmd = CMD_DES;
   end

   seq_state_t          state_q, state_d;
   logic [NUM_MR-1:0]   work_q, work_d, pend_q, pend_d, req_mask, go_mask;
   logic                busy_q, busy_d, blk_q, blk_d, done_q, done_d;
   ddr_cmd_t            cmd_q, cmd_d;
   logic [BA_W-1:0]     ba_q, ba_d;
   logic [ADDR_W-1:0]   addr_q, addr_d;
   logic                cap, t_load, t_exp;
   logic [CNT_W-1:0]    t_val, mrd_m1, mod_m1, guard_len;
   logic                pick_any;
   logic [SEL_W-1:0]    pick_sel;
   logic [NUM_MR-1:0]   pick_rest;
   logic [ADDR_W-1:0]   shadow_data;

   assign req_mask  = {NUM_MR{init_req}} | (upd_req ? upd_mask : '0);
   assign go_mask   = pend_q | req_mask;
   assign mrd_m1    = (t_mrd == '0) ? '0 : t_mrd - 1'b1;
   assign mod_m1    = (t_mod == '0) ? '0 : t_mod - 1'b1;
   assign guard_len = rtt_nom_on ? t_odtloff : '0;

   mrs_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp)
   );

   mrs_picker #(.NUM(NUM_MR)) u_pick (
      .mask(work_q), .any(pick_any), .sel(pick_sel), .rest(pick_rest)
   );

   mrs_shadow #(.ADDR_W(ADDR_W), .NUM(NUM_MR)) u_shadow (
      .clk(clk), .rst_n(rst_n), .cap(cap),
      .img_flat({mr3_img, mr2_img, mr1_img, mr0_img}),
      .rd_sel(pick_sel), .rd_data(shadow_data)
   );

   always_comb begin
      state_d = state_q;
      work_d  = work_q;
      pend_d  = pend_q;
      busy_d  = busy_q;
      blk_d   = blk_q;
      done_d  = 1'b0;
      cmd_d   = CMD_NOP;
      ba_d    = '0;
      addr_d  = '0;
      cap     = 1'b0;
      t_load  = 1'b0;
      t_val   = '0;
      case (state_q)
         ST_IDLE: begin
            if (req_mask != '0) begin
               state_d = ST_GUARD;
               work_d  = req_mask;
               cap     = 1'b1;
               busy_d  = 1'b1;
               blk_d   = 1'b1;
               t_load  = 1'b1;
               t_val   = guard_len;
            end
         end
         ST_GUARD, ST_GAP: begin
            pend_d = pend_q | req_mask;
            if (t_exp && pick_any) begin
               cmd_d  = CMD_MRS;
               ba_d   = BA_W'(pick_sel);
               addr_d = shadow_data;
               work_d = pick_rest;
               t_load = 1'b1;
               if (pick_rest != '0) begin
                  state_d = ST_GAP;
                  t_val   = mrd_m1;
               end else begin
                  state_d = ST_SETTLE;
                  t_val   = mod_m1;
               end
            end
         end
         ST_SETTLE: begin
            pend_d = pend_q | req_mask;
            if (t_exp) begin
               done_d = 1'b1;
               pend_d = '0;
               if (go_mask != '0) begin
                  state_d = ST_GUARD;
                  work_d  = go_mask;
                  cap     = 1'b1;
                  t_load  = 1'b1;
                  t_val   = guard_len;
               end else begin
                  state_d = ST_IDLE;
                  busy_d  = 1'b0;
                  blk_d   = 1'b0;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
      if (!busy_d) cmd_d = idle_cmd;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         work_q  <= '0;
         pend_q  <= '0;
         busy_q  <= 1'b0;
         blk_q   <= 1'b0;
         done_q  <= 1'b0;
         cmd_q   <= idle_cmd;
         ba_q    <= '0;
         addr_q  <= '0;
      end else begin
         state_q <= state_d;
         work_q  <= work_d;
         pend_q  <= pend_d;
         busy_q  <= busy_d;
         blk_q   <= blk_d;
         done_q  <= done_d;
         cmd_q   <= cmd_d;
         ba_q    <= ba_d;
         addr_q  <= addr_d;
      end
   end

   assign cs_n  = cmd_q.cs_n;
   assign ras_n = cmd_q.ras_n;
   assign cas_n = cmd_q.cas_n;
   assign we_n  = cmd_q.we_n;
   assign ba    = ba_q;
   assign addr  = addr_q;
   assign busy  = busy_q;
   assign done  = done_q;
   assign odt   = odt_req & ~blk_q;

   // cycles since the last MRS on the bus, for the spacing check
   logic             mrs_now, seen_q;
   logic [GAP_W-1:0] gap_q;
   assign mrs_now = (cmd_q == CMD_MRS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (mrs_now) begin
         gap_q  <= GAP_W'(1);
         seen_q <= 1'b1;
      end else if (gap_q != '1) begin
         gap_q  <= gap_q + 1'b1;
      end
   end

   AST_MRS_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (mrs_now && seen_q) |-> (gap_q >= GAP_W'(t_mrd))); // R5
   AST_ODT_LOW_AT_MRS: assert property (@(posedge clk) disable iff (!rst_n)
      mrs_now |-> !odt); // R8
   AST_ODT_LOW_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !odt); // R8
   AST_MRS_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mrs_now |-> busy); // R6
   AST_IDLE_NO_MRS: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mrs_now); // R6
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_QUEUE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q != '0) |-> busy); // R9
   AST_PICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      pick_any |-> ($countones(pick_rest) == $countones(work_q) - 1)); // R3
endmodule

// File: tb/mrs_sequencer_test.sv
`timescale 1ns/1ps
module mrs_sequencer_test;
   localparam int AW = 16;
   localparam int BW = 3;
   localparam int CW = 8;
   localparam logic [3:0] C_MRS = 4'b0000;
   localparam logic [3:0] C_NOP = 4'b0111;
   localparam logic [3:0] C_DES = 4'b1111;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n, init_req, upd_req, rtt_nom_on, odt_req;
   logic [3:0]    upd_mask;
   logic [AW-1:0] cur [4];
   logic [AW-1:0] img_a [4];
   logic [AW-1:0] img_b [4];
   logic [CW-1:0] t_mrd, t_mod, t_odtloff;
   logic          cs_n, ras_n, cas_n, we_n, odt, busy, done;
   logic [BW-1:0] ba;
   logic [AW-1:0] addr;

   mrs_sequencer #(.ADDR_W(AW), .BA_W(BW), .CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .init_req(init_req), .upd_req(upd_req),
      .upd_mask(upd_mask), .mr0_img(cur[0]), .mr1_img(cur[1]),
      .mr2_img(cur[2]), .mr3_img(cur[3]), .rtt_nom_on(rtt_nom_on),
      .t_mrd(t_mrd), .t_mod(t_mod), .t_odtloff(t_odtloff), .odt_req(odt_req),
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba),
      .addr(addr), .odt(odt), .busy(busy), .done(done)
   );

   int vectors = 0;
   int miscompares = 0;

   bit            e_mrs   [256];
   int            e_ba    [256];
   logic [AW-1:0] e_addr  [256];
   int            e_seq   [256];
   bit            e_first [256];

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic int order_reg(input int slot);
      case (slot)
         0: return 2;
         1: return 3;
         2: return 1;
         default: return 0;
      endcase
   endfunction

   function automatic int eff(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   task automatic plan_seq(input int base, input logic [3:0] m, input int g, input int gap,
                           input int settle, input int seqno, output int endc);
      int  t    = base + 2 + g;
      int  last = t;
      bit  first = 1'b1;
      for (int s = 0; s < 4; s++) begin
         int r = order_reg(s);
         if (m[r]) begin
            e_mrs[t]   = 1'b1;
            e_ba[t]    = r;
            e_addr[t]  = (seqno == 1) ? img_a[r] : img_b[r];
            e_seq[t]   = seqno;
            e_first[t] = first;
            first      = 1'b0;
            last       = t;
            t          = t + gap;
         end
      end
      endc = last + settle;
   endtask

   task automatic run_case(input logic [3:0] m1, input logic [3:0] qm, input bit rtt,
                           input int mrd, input int mod, input int odtl);
      int g, end1, end2, fin;
      for (int i = 0; i < 256; i++) begin
         e_mrs[i] = 1'b0; e_ba[i] = 0; e_addr[i] = '0; e_seq[i] = 0; e_first[i] = 1'b0;
      end
      for (int i = 0; i < 4; i++) begin
         img_a[i] = AW'($urandom);
         img_b[i] = AW'($urandom);
         cur[i]   = img_a[i];
      end
      t_mrd = CW'(mrd); t_mod = CW'(mod); t_odtloff = CW'(odtl); rtt_nom_on = rtt;
      g = rtt ? odtl : 0;
      plan_seq(0, m1, g, eff(mrd), eff(mod), 1, end1);
      fin  = end1;
      end2 = -1;
      if (qm != 4'h0) begin
         plan_seq(end1 - 1, qm, g, eff(mrd), eff(mod), 2, end2);
         fin = end2;
      end
      if (m1 == 4'hF) init_req = 1'b1;
      else begin upd_req = 1'b1; upd_mask = m1; end
      for (int n = 1; n <= fin + 3; n++) begin
         bit bz;
         @(negedge clk);
         bz = (n < fin);
         check("R6 busy", 32'(busy), 32'(bz));
         check("R7 done", 32'(done), 32'((n == end1) || (n == end2)));
         check("R8 odt", 32'(odt), 32'(!bz));
         if (e_mrs[n]) begin
            check(e_seq[n] == 2 ? "R9 queued MRS slot" :
                  (e_first[n] ? "R2/R4 first MRS slot" : "R2/R5 MRS slot"),
                  32'({cs_n, ras_n, cas_n, we_n}), 32'(C_MRS));
            check("R3 register order", 32'(ba), 32'(e_ba[n]));
            check(e_seq[n] == 2 ? "R9 image" : "R11 image", 32'(addr), 32'(e_addr[n]));
         end else begin
            check("R6 filler command", 32'({cs_n, ras_n, cas_n, we_n}),
                  32'(bz ? C_NOP : C_DES));
         end
         if (n == 1) begin init_req = 1'b0; upd_req = 1'b0; upd_mask = '0; end
         if (n == 3) begin
            for (int i = 0; i < 4; i++) cur[i] = img_b[i];
            if (qm != 4'h0) begin upd_req = 1'b1; upd_mask = qm; end
         end
         if (n == 4) begin upd_req = 1'b0; upd_mask = '0; end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; init_req = 1'b0; upd_req = 1'b0; upd_mask = '0;
      rtt_nom_on = 1'b0; odt_req = 1'b1;
      t_mrd = 8'd4; t_mod = 8'd12; t_odtloff = 8'd0;
      for (int i = 0; i < 4; i++) cur[i] = '0;
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset command", 32'({cs_n, ras_n, cas_n, we_n}), 32'(C_DES));
      check("R1 reset busy", 32'(busy), 32'h0);
      check("R1 reset done", 32'(done), 32'h0);
      check("R1 reset odt", 32'(odt), 32'h1);

      // directed: full init with defaults, termination on and off
      run_case(4'hF, 4'h0, 1'b1, 4, 12, 7);
      run_case(4'hF, 4'h0, 1'b0, 4, 12, 7);
      // zero gap clamps to one cycle
      run_case(4'hF, 4'h0, 1'b0, 0, 3, 0);
      // single register update, then queued update
      run_case(4'h2, 4'h0, 1'b1, 2, 5, 3);
      run_case(4'h9, 4'h6, 1'b1, 3, 6, 2);
      run_case(4'h1, 4'hF, 1'b0, 1, 3, 0);

      // R10: empty mask is ignored
      @(negedge clk);
      upd_req = 1'b1; upd_mask = 4'h0;
      @(negedge clk);
      upd_req = 1'b0;
      for (int n = 0; n < 5; n++) begin
         @(negedge clk);
         check("R10 ignored busy", 32'(busy), 32'h0);
         check("R10 ignored command", 32'({cs_n, ras_n, cas_n, we_n}), 32'(C_DES));
         check("R10 ignored done", 32'(done), 32'h0);
      end

      for (int k = 0; k < 24; k++) begin
         logic [3:0] m1, qm;
         int mrd, mod, odtl;
         m1   = 4'($urandom_range(1, 15));
         qm   = ($urandom_range(0, 1) == 1) ? 4'($urandom_range(1, 15)) : 4'h0;
         mrd  = $urandom_range(0, 6);
         mod  = eff(mrd) + 3 + $urandom_range(0, 9);
         odtl = $urandom_range(0, 7);
         run_case(m1, qm, 1'($urandom_range(0, 1)), mrd, mod, odtl);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule